// File: doc/BRIEF.md
# AXI Write Burst Beat and Strobe Monitor

This block watches the write address and write data channels of an AXI4 port without driving either one. It checks two things on every write burst. The first is that the number of data beats agrees with the burst length carried by the address request, with the last-beat marker on the final beat and on no other beat. The second is that each beat sets strobes only on byte lanes that are legal for that beat. Legal lanes depend on the start address, the transfer size, the burst type and the beat's position in the burst.

Accepted address requests wait in a small in-order queue until their data finishes. Data may run ahead of its address. Those beats are tallied in a side counter, and when the address arrives the tally is compared with its length. Each violation is reported as a one-cycle pulse on a registered flag, so the block can drive an interrupt, a counter or a simulation log.

Top module: `wr_beat_monitor`

## Requirements
- R1: While reset is high, and on the first cycle after reset falls, all four flags are low. Reset clears the queue, the beat counter and the side counter.
- R2: A data beat with the last marker set whose zero-based index differs from the burst length field (beats minus one) raises `count_err_o` one cycle after that beat.
- R3: A data beat without the last marker whose zero-based index is equal to or greater than the length field raises `count_err_o` one cycle after that beat.
- R4: A burst whose beats, last marker and strobes are all correct raises no flag.
- R5: Beats that arrive with no address are counted. When the address later arrives, the count is compared with length+1, and a mismatch raises `count_err_o` one cycle after the address handshake. An address that arrives in the middle of such a burst takes over the running count.
- R6: For burst type 1 (incrementing), beat 0 may use lanes from the start address's low bits up to the end of the naturally aligned container of 2^size bytes. A later beat n uses the container at aligned start + n·2^size. A strobe outside these lanes raises `strb_err_o` one cycle after the beat.
- R7: For burst type 0 (fixed), every beat uses the lane window of beat 0.
- R8: For burst type 2 (wrapping), the beat address wraps inside a window of (length+1)·2^size bytes aligned to that size.
- R9: A beat is counted only on a cycle with both `w_valid` and `w_ready` high. An address is taken only with both `aw_valid` and `aw_ready` high.
- R10: An address handshake while the queue holds MAX_WBURSTS requests, with no request retiring in that cycle, raises `overflow_o` one cycle later and discards the request.
- R11: A data beat with no address while a completed address-less burst is already waiting raises `underflow_o` one cycle later. That beat is ignored.
- R12: Beats with no known address get no strobe check. Burst type 3 (reserved) treats every lane as legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aw_valid | input | 1 | Address channel valid |
| aw_ready | input | 1 | Address channel ready |
| aw_addr | input | ADDR_W | Burst start address |
| aw_len | input | 8 | Beats minus one |
| aw_size | input | 3 | log2 of bytes per beat |
| aw_burst | input | 2 | 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| w_valid | input | 1 | Data channel valid |
| w_ready | input | 1 | Data channel ready |
| w_strb | input | DATA_W/8 | Byte lane strobes |
| w_last | input | 1 | Last beat marker |
| count_err_o | output | 1 | Beat count or last-marker violation pulse |
| strb_err_o | output | 1 | Illegal strobe lane pulse |
| overflow_o | output | 1 | Address queue overflow pulse |
| underflow_o | output | 1 | Data with no address and no room to hold it |

## Verification
Every flag is set by the clock edge that samples the offending handshake, so each result is due exactly one cycle after its stimulus. This holds even for a late-address count mismatch, which is due one cycle after the address handshake rather than after the data. The bench drives each stimulus cycle on a falling edge and lets one rising edge pass. It then samples the flags 1 ns later, before the next stimulus is applied, so every check sees the response to exactly one input cycle. A flag that should stay low is checked in that same slot, so a pulse that arrives late, early or for the wrong cycle is reported.

// File: rtl/wbeat_pkg.sv
package wbeat_pkg;
  localparam int LEN_W  = 8;
  localparam int SIZE_W = 3;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2,
    BURST_RSVD  = 2'd3
  } burst_e;
endpackage

// File: rtl/wbeat_req_fifo.sv
module wbeat_req_fifo #(
  parameter int WIDTH = 45,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_W'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rp];

  // storage has no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wbeat_lane_mask.sv
module wbeat_lane_mask
  import wbeat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STRB_W = 4
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  input  burst_e            burst,
  input  logic [LEN_W:0]    beat,
  output logic [STRB_W-1:0] mask
);
  localparam int LANE_W = (STRB_W > 1) ? $clog2(STRB_W) : 1;

  logic [ADDR_W-1:0] unit, aligned, step, window, beat_addr;
  logic [LANE_W-1:0] lo;
  logic [STRB_W-1:0] above;

  always_comb begin
    unit    = ADDR_W'(1) << size;
    aligned = start_addr & ~(unit - 1'b1);
    step    = ADDR_W'(beat) << size;
    window  = (ADDR_W'(len) + 1'b1) << size;
    unique case (burst)
      BURST_INCR: beat_addr = (beat == '0) ? start_addr : aligned + step;
      BURST_WRAP: beat_addr = (beat == '0) ? start_addr :
                  ((start_addr & ~(window - 1'b1)) | ((aligned + step) & (window - 1'b1)));
      default:    beat_addr = start_addr;
    endcase
  end

  assign lo    = beat_addr[LANE_W-1:0];
  assign above = ~((STRB_W'(1) << lo) - 1'b1);

  for (genvar g = 0; g < STRB_W; g++) begin : g_lane
    assign mask[g] = (burst == BURST_RSVD) ||
                     (above[g] && (((LANE_W'(g) ^ lo) >> size) == '0));
  end
endmodule

// File: rtl/wr_beat_monitor.sv
module wr_beat_monitor
  import wbeat_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int MAX_WBURSTS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                aw_valid,
  input  logic                aw_ready,
  input  logic [ADDR_W-1:0]   aw_addr,
  input  logic [7:0]          aw_len,
  input  logic [2:0]          aw_size,
  input  logic [1:0]          aw_burst,
  input  logic                w_valid,
  input  logic                w_ready,
  input  logic [DATA_W/8-1:0] w_strb,
  input  logic                w_last,
  output logic                count_err_o,
  output logic                strb_err_o,
  output logic                overflow_o,
  output logic                underflow_o
);
  localparam int STRB_W = DATA_W / 8;
  localparam int REQ_W  = ADDR_W + LEN_W + SIZE_W + 2;
  localparam int CNT_W  = LEN_W + 1;

  logic              aw_hs, w_hs, q_empty, q_full, push, pop;
  logic [REQ_W-1:0]  head;
  logic [ADDR_W-1:0] h_addr, c_addr;
  logic [LEN_W-1:0]  h_len, c_len;
  logic [SIZE_W-1:0] h_size, c_size;
  logic [1:0]        h_burst, c_burst;
  logic [STRB_W-1:0] legal;
  logic [CNT_W-1:0]  beat_cnt, early_cnt;
  logic              early_done, bypass, have_addr, resolve, orphan_cnt, orphan_drop;
  logic              cnt_bad, early_bad, strb_bad;

  assign aw_hs = aw_valid && aw_ready;
  assign w_hs  = w_valid && w_ready;
  assign {h_addr, h_len, h_size, h_burst} = head;

  // address for the current beat: queue head, or the same-cycle request
  assign resolve     = aw_hs && early_done;
  assign bypass      = q_empty && aw_hs && !early_done;
  assign have_addr   = !q_empty || bypass;
  assign orphan_drop = w_hs && !have_addr && early_done && !aw_hs;
  assign orphan_cnt  = w_hs && !have_addr && !orphan_drop;

  assign c_addr  = q_empty ? aw_addr  : h_addr;
  assign c_len   = q_empty ? aw_len   : h_len;
  assign c_size  = q_empty ? aw_size  : h_size;
  assign c_burst = q_empty ? aw_burst : h_burst;

  assign push = aw_hs && !resolve && !(bypass && w_hs && w_last);
  assign pop  = w_hs && !q_empty && w_last;

  wbeat_req_fifo #(.WIDTH(REQ_W), .DEPTH(MAX_WBURSTS)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .din({aw_addr, aw_len, aw_size, aw_burst}),
    .dout(head), .empty(q_empty), .full(q_full)
  );

  wbeat_lane_mask #(.ADDR_W(ADDR_W), .STRB_W(STRB_W)) u_mask (
    .start_addr(c_addr), .len(c_len), .size(c_size),
    .burst(burst_e'(c_burst)), .beat(beat_cnt), .mask(legal)
  );

  assign cnt_bad   = w_last ? (beat_cnt != CNT_W'(c_len)) : (beat_cnt >= CNT_W'(c_len));
  assign early_bad = resolve && (early_cnt != CNT_W'(aw_len) + 1'b1);
  assign strb_bad  = |(w_strb & ~legal);

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_cnt    <= '0;
      early_cnt   <= '0;
      early_done  <= 1'b0;
      count_err_o <= 1'b0;
      strb_err_o  <= 1'b0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
    end else begin
      count_err_o <= (w_hs && have_addr && cnt_bad) || early_bad;
      strb_err_o  <= w_hs && have_addr && strb_bad;
      overflow_o  <= push && q_full && !pop;
      underflow_o <= orphan_drop;

      if (w_hs && (have_addr || orphan_cnt)) begin
        if (w_last)              beat_cnt <= '0;
        else if (beat_cnt != '1) beat_cnt <= beat_cnt + 1'b1;
      end

      if (orphan_cnt && w_last) begin
        early_done <= 1'b1;
        early_cnt  <= (beat_cnt != '1) ? beat_cnt + 1'b1 : beat_cnt;
      end else if (resolve) begin
        early_done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wr_beat_monitor_sva.sv
module wr_beat_monitor_sva (
  input logic clk,
  input logic rst,
  input logic aw_valid,
  input logic aw_ready,
  input logic w_valid,
  input logic w_ready,
  input logic count_err_o,
  input logic strb_err_o,
  input logic overflow_o,
  input logic underflow_o
);
  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(count_err_o || strb_err_o || overflow_o || underflow_o));

  // R9
  strb_needs_beat_chk: assert property (@(posedge clk) disable iff (rst)
    strb_err_o |-> $past(w_valid && w_ready));

  // R2
  count_needs_hs_chk: assert property (@(posedge clk) disable iff (rst)
    count_err_o |-> $past((w_valid && w_ready) || (aw_valid && aw_ready)));

  // R10
  overflow_needs_aw_chk: assert property (@(posedge clk) disable iff (rst)
    overflow_o |-> $past(aw_valid && aw_ready));

  // R11
  underflow_needs_beat_chk: assert property (@(posedge clk) disable iff (rst)
    underflow_o |-> $past(w_valid && w_ready));

  // R12
  no_strobe_on_orphan_chk: assert property (@(posedge clk) disable iff (rst)
    underflow_o |-> !strb_err_o);
endmodule

bind wr_beat_monitor wr_beat_monitor_sva u_sva (.*);

// File: tb/wr_beat_monitor_bench.sv
`timescale 1ns/1ps
module wr_beat_monitor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        aw_valid = 1'b0, aw_ready = 1'b0;
  logic [31:0] aw_addr = '0;
  logic [7:0]  aw_len = '0;
  logic [2:0]  aw_size = '0;
  logic [1:0]  aw_burst = '0;
  logic        w_valid = 1'b0, w_ready = 1'b0, w_last = 1'b0;
  logic [3:0]  w_strb = '0;
  logic        count_err_o, strb_err_o, overflow_o, underflow_o;
  int          checks = 0;
  int          fails = 0;

  always #2.5 clk = ~clk;

  wr_beat_monitor u_wr_beat_monitor (.*);

  typedef struct packed {
    logic        awv, awr;
    logic [31:0] addr;
    logic [7:0]  len;
    logic [2:0]  size;
    logic [1:0]  burst;
    logic        wv, wr;
    logic [3:0]  strb;
    logic        last;
    logic [3:0]  exp;  // {count, strobe, overflow, underflow}
    logic [7:0]  tag;
  } row_t;

  localparam int N = 47;
  localparam row_t ROWS [N] = '{
    // R6/R4 incrementing, unaligned start, half-word beats
    '{1'b1,1'b1,32'h1002,8'd2,3'd1,2'd1,1'b1,1'b1,4'hC,1'b0,4'h0,8'd6},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'h3,1'b0,4'h0,8'd6},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hC,1'b1,4'h0,8'd4},
    // R6 lane below unaligned start
    '{1'b1,1'b1,32'h2001,8'd1,3'd2,2'd1,1'b1,1'b1,4'hF,1'b0,4'h4,8'd6},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b1,4'h0,8'd6},
    // R7 fixed burst, queued address
    '{1'b1,1'b1,32'h3001,8'd2,3'd0,2'd0,1'b0,1'b0,4'h0,1'b0,4'h0,8'd7},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'h2,1'b0,4'h0,8'd7},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'h2,1'b0,4'h0,8'd7},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'h4,1'b1,4'h4,8'd7},
    // R8 wrapping burst, two-byte window
    '{1'b1,1'b1,32'h4001,8'd1,3'd0,2'd2,1'b1,1'b1,4'h2,1'b0,4'h0,8'd8},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'h1,1'b1,4'h0,8'd8},
    '{1'b1,1'b1,32'h4001,8'd1,3'd0,2'd2,1'b1,1'b1,4'h2,1'b0,4'h0,8'd8},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'h4,1'b1,4'h4,8'd8},
    // R2 last marker too early
    '{1'b1,1'b1,32'h5000,8'd3,3'd2,2'd1,1'b1,1'b1,4'hF,1'b0,4'h0,8'd2},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b1,4'h8,8'd2},
    // R3 missing last marker, then late last
    '{1'b1,1'b1,32'h6000,8'd0,3'd2,2'd1,1'b1,1'b1,4'hF,1'b0,4'h8,8'd3},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b1,4'h8,8'd3},
    // R9 valid without ready is ignored on both channels
    '{1'b1,1'b1,32'h7100,8'd1,3'd2,2'd1,1'b1,1'b0,4'hF,1'b1,4'h0,8'd9},
    '{1'b1,1'b0,32'h7200,8'd0,3'd2,2'd1,1'b0,1'b0,4'h0,1'b0,4'h0,8'd9},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b0,4'h0,8'd9},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b1,4'h0,8'd9},
    // R5 data ahead of address
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b0,4'h0,8'd5},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b1,4'h0,8'd5},
    '{1'b1,1'b1,32'h7300,8'd1,3'd2,2'd1,1'b0,1'b0,4'h0,1'b0,4'h0,8'd5},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b0,4'h0,8'd5},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b1,4'h0,8'd5},
    '{1'b1,1'b1,32'h7400,8'd2,3'd2,2'd1,1'b0,1'b0,4'h0,1'b0,4'h8,8'd5},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b0,4'h0,8'd5},
    '{1'b1,1'b1,32'h7000,8'd1,3'd2,2'd1,1'b1,1'b1,4'hF,1'b1,4'h0,8'd5},
    // R12 no strobe check without address; reserved burst
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'h8,1'b1,4'h0,8'd12},
    '{1'b1,1'b1,32'h9000,8'd0,3'd0,2'd1,1'b0,1'b0,4'h0,1'b0,4'h0,8'd12},
    '{1'b1,1'b1,32'h8001,8'd0,3'd0,2'd3,1'b1,1'b1,4'hF,1'b1,4'h0,8'd12},
    // R11 underflow
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b0,4'h0,8'd11},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b1,4'h0,8'd11},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b1,4'h1,8'd11},
    '{1'b1,1'b1,32'h7500,8'd1,3'd2,2'd1,1'b0,1'b0,4'h0,1'b0,4'h0,8'd11},
    // R10 overflow of a four-deep queue
    '{1'b1,1'b1,32'hA000,8'd0,3'd2,2'd1,1'b0,1'b0,4'h0,1'b0,4'h0,8'd10},
    '{1'b1,1'b1,32'hA000,8'd0,3'd2,2'd1,1'b0,1'b0,4'h0,1'b0,4'h0,8'd10},
    '{1'b1,1'b1,32'hA000,8'd0,3'd2,2'd1,1'b0,1'b0,4'h0,1'b0,4'h0,8'd10},
    '{1'b1,1'b1,32'hA000,8'd0,3'd2,2'd1,1'b0,1'b0,4'h0,1'b0,4'h0,8'd10},
    '{1'b1,1'b1,32'hA000,8'd0,3'd2,2'd1,1'b0,1'b0,4'h0,1'b0,4'h2,8'd10},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b1,4'h0,8'd10},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b1,4'h0,8'd10},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b1,4'h0,8'd10},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b1,4'h0,8'd10},
    '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b1,4'h0,8'd10},
    '{1'b1,1'b1,32'hA100,8'd0,3'd2,2'd1,1'b0,1'b0,4'h0,1'b0,4'h0,8'd10}
  };

  function automatic logic [3:0] flags();
    return {count_err_o, strb_err_o, overflow_o, underflow_o};
  endfunction

  task automatic check(input int tag, input string what, input logic [3:0] exp);
    checks++;
    if (flags() !== exp) begin
      fails++;
      $display("FAIL R%0d %s: flags=%b expected %b", tag, what, flags(), exp);
    end
  endtask

  task automatic drive(input row_t r);
    aw_valid = r.awv; aw_ready = r.awr; aw_addr = r.addr; aw_len = r.len;
    aw_size = r.size; aw_burst = r.burst;
    w_valid = r.wv; w_ready = r.wr; w_strb = r.strb; w_last = r.last;
  endtask

  localparam row_t IDLE = '{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b0,1'b0,4'h0,1'b0,4'h0,8'd0};

  initial begin
    // R1: stimulus during reset has no effect
    drive('{1'b1,1'b1,32'h1,8'd0,3'd2,2'd1,1'b1,1'b1,4'hF,1'b0,4'h0,8'd1});
    repeat (3) @(posedge clk);
    #1 check(1, "during reset", 4'h0);
    @(negedge clk); drive(IDLE); rst = 1'b0;
    @(posedge clk); #1 check(1, "first cycle after reset", 4'h0);

    for (int i = 0; i < N; i++) begin
      @(negedge clk); drive(ROWS[i]);
      @(posedge clk); #1 check(ROWS[i].tag, $sformatf("row %0d", i), ROWS[i].exp);
    end
    @(negedge clk); drive(IDLE);

    // R1: reset drops a queued request
    @(negedge clk); drive('{1'b1,1'b1,32'hB000,8'd1,3'd2,2'd1,1'b0,1'b0,4'h0,1'b0,4'h0,8'd1});
    @(negedge clk); drive(IDLE); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    drive('{1'b0,1'b0,32'h0,8'd0,3'd0,2'd0,1'b1,1'b1,4'hF,1'b1,4'h0,8'd1});
    @(posedge clk); #1 check(1, "beat after reset not matched to old request", 4'h0);
    @(negedge clk); drive('{1'b1,1'b1,32'hB100,8'd0,3'd2,2'd1,1'b0,1'b0,4'h0,1'b0,4'h0,8'd1});
    @(posedge clk); #1 check(1, "late address after reset", 4'h0);
    @(negedge clk); drive(IDLE);
    @(posedge clk); #1 check(4, "idle stays quiet", 4'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog: actual hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule